// File: doc/BRIEF.md
# Descriptor Ring Transmit Engine

The engine walks a circular list of four-word transmit descriptors kept in a small internal word memory, turning each one the device owns into a stream of bytes. Host software fills the memory through a write port and reads it back through a read port. It loads a ring base register, then writes a poll-demand register to start the walk. For each descriptor the engine reads all four words. If the descriptor is owned by the device, it streams the buffer bytes out one per cycle, padding short frames with zeros. It then writes a status word of zero back, which returns the descriptor to the host, and moves on to the next descriptor. Setup descriptors are consumed without being sent.

The walk stops when the engine meets a descriptor that the host owns. It starts again only on the next poll-demand write. Each descriptor holds four words: status, control, buffer address and next address. The byte addresses in the descriptor index the same internal memory.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset, tx_valid and tx_irq are low and stay low until a poll demand is written.
- R2: A descriptor whose status word has bit 31 clear is not processed. The engine halts on it and does nothing more until the host writes the poll-demand register (host_reg=1, host_addr[0]=1). After that write it fetches the same descriptor again.
- R3: An owned descriptor sends the number of bytes in control bits 10:0, starting at the buffer byte address in word 2 and moving through ascending addresses. Byte address a is byte lane a%4 (bits 8*(a%4)+7:8*(a%4)) of memory word a/4.
- R4: Control bit 29 starts a frame and bit 30 ends it. A frame with a total length below 60 bytes gets zero bytes appended up to 60. tx_last is high only on the final byte of the frame, whether that byte is data or padding.
- R5: A descriptor with control bit 27 set is a setup descriptor. None of its bytes appear on tx_valid, but it is still written back.
- R6: On completion the status word of the descriptor is written with the value 0, so bit 31 is clear.
- R7: After the write-back, tx_irq pulses high for exactly one cycle if control bit 31 was set. It stays low if that bit was clear.
- R8: Control bit 25 sends the engine back to the ring base after the descriptor. Otherwise bit 24 sends it to the byte address in word 3. Otherwise it goes to the descriptor 16 bytes further on. Bit 25 takes precedence over bit 24.
- R9: A register write with host_reg=1 and host_addr[0]=0 loads the ring base from host_wdata bits AW+1:2. The same write moves the current descriptor pointer there, and the next poll starts from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_reg | input | 1 | 1: register write, 0: memory write |
| host_addr | input | AW | Memory word address, or register select in bit 0 |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | AW | Host memory read word address |
| host_rdata | output | 32 | Memory read data, one cycle after host_raddr |
| tx_valid | output | 1 | Byte valid on tx_data |
| tx_data | output | 8 | Transmitted byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_irq | output | 1 | One-cycle completion interrupt |

## Verification
The first byte leaves the engine eight cycles after the poll-demand write. After that, bytes follow one per cycle, with a one-cycle gap at each word boundary. The bench does not fix those cycles. Instead it holds the expected bytes and tx_last flags in a queue, computed from the descriptors it wrote, and on every falling edge it compares any valid byte with the head of the queue, so a byte that arrives early, late or without being expected is caught in the cycle it appears. Write-back words and interrupt counts are due a few cycles after the last byte. The bench reads them only after the queue has drained and a fixed settle of 30 cycles has passed. The halt window is held for 40 idle cycles with a byte counter that must not move.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int OWN_BIT   = 31;
  localparam int IRQ_BIT   = 31;
  localparam int LS_BIT    = 30;
  localparam int FS_BIT    = 29;
  localparam int SETUP_BIT = 27;
  localparam int EOR_BIT   = 25;
  localparam int CHAIN_BIT = 24;
  localparam int CNT_W     = 11;
  localparam int DESC_WORDS = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_D0, S_D1, S_D2, S_D3, S_DEC, S_SRD, S_SBY, S_PAD, S_WB
  } eng_state_t;
endpackage

// File: rtl/tx_ring_mem.sv
module tx_ring_mem #(
  parameter int AW  = 8,
  parameter int NRD = 2
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [31:0]          wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][31:0]   rdata
);
  localparam int WORDS = 1 << AW;

  logic [31:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[g] <= ram[raddr[g]];
    end
  end
endmodule

// File: rtl/tx_ring_regs.sv
module tx_ring_regs #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          sel_poll,
  input  logic [AW-1:0] wval,
  output logic [AW-1:0] base_word,
  output logic          base_load,
  output logic          poll
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_word <= '0;
      base_load <= 1'b0;
      poll      <= 1'b0;
    end else begin
      base_load <= wr && !sel_poll;
      poll      <= wr && sel_poll;
      if (wr && !sel_poll) base_word <= wval;
    end
  end
endmodule

// File: rtl/tx_ring_seq.sv
module tx_ring_seq
  import tx_ring_pkg::*;
#(
  parameter int AW      = 8,
  parameter int MIN_LEN = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          poll,
  input  logic          base_load,
  input  logic [AW-1:0] base_word,
  input  logic          host_busy,
  input  logic [31:0]   rd_data,
  output logic [AW-1:0] eng_addr,
  output logic          eng_we,
  output logic [31:0]   eng_wdata,
  output logic          busy,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          irq
);
  localparam int BAW = AW + 2;
  localparam int FLW = 16;

  eng_state_t state;
  logic [AW-1:0]    cur;
  logic             d_own;
  logic             c_irq, c_ls, c_fs, c_setup, c_eor, c_chain;
  logic [CNT_W-1:0] c_cnt;
  logic [BAW-1:0]   b1;
  logic [AW-1:0]    b2;
  logic [BAW-1:0]   bp;
  logic [CNT_W-1:0] rem;
  logic [FLW-1:0]   flen;
  logic [FLW-1:0]   flen_start;
  logic [FLW-1:0]   flen_nx;
  logic [AW-1:0]    nxt;
  logic [7:0]       lane_byte;

  assign flen_start = c_fs ? '0 : flen;
  assign flen_nx    = flen + FLW'(1);
  assign lane_byte  = rd_data[{bp[1:0], 3'b000} +: 8];
  assign busy       = (state != S_IDLE);
  assign eng_wdata  = '0;
  assign eng_we     = (state == S_WB) && !host_busy;

  always_comb begin
    if (c_eor)        nxt = base_word;
    else if (c_chain) nxt = b2;
    else              nxt = cur + AW'(DESC_WORDS);
  end

  always_comb begin
    case (state)
      S_D1:         eng_addr = cur + AW'(1);
      S_D2:         eng_addr = cur + AW'(2);
      S_D3:         eng_addr = cur + AW'(3);
      S_SRD, S_SBY: eng_addr = bp[BAW-1:2];
      default:      eng_addr = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur       <= '0;
      d_own     <= 1'b0;
      c_irq     <= 1'b0;
      c_ls      <= 1'b0;
      c_fs      <= 1'b0;
      c_setup   <= 1'b0;
      c_eor     <= 1'b0;
      c_chain   <= 1'b0;
      c_cnt     <= '0;
      b1        <= '0;
      b2        <= '0;
      bp        <= '0;
      rem       <= '0;
      flen      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      irq       <= 1'b0;
      if (base_load) cur <= base_word;
      case (state)
        S_IDLE: if (poll) state <= S_D0;
        S_D0:   state <= S_D1;
        S_D1: begin
          d_own <= rd_data[OWN_BIT];
          state <= S_D2;
        end
        S_D2: begin
          c_irq   <= rd_data[IRQ_BIT];
          c_ls    <= rd_data[LS_BIT];
          c_fs    <= rd_data[FS_BIT];
          c_setup <= rd_data[SETUP_BIT];
          c_eor   <= rd_data[EOR_BIT];
          c_chain <= rd_data[CHAIN_BIT];
          c_cnt   <= rd_data[CNT_W-1:0];
          state   <= S_D3;
        end
        S_D3: begin
          b1    <= rd_data[BAW-1:0];
          state <= S_DEC;
        end
        S_DEC: begin
          b2   <= rd_data[BAW-1:2];
          bp   <= b1;
          rem  <= c_cnt;
          flen <= flen_start;
          if (!d_own)                                     state <= S_IDLE;
          else if (c_setup)                               state <= S_WB;
          else if (c_cnt != '0)                           state <= S_SRD;
          else if (c_ls && (flen_start < FLW'(MIN_LEN)))  state <= S_PAD;
          else                                            state <= S_WB;
        end
        S_SRD: state <= S_SBY;
        S_SBY: begin
          out_valid <= 1'b1;
          out_data  <= lane_byte;
          flen      <= flen_nx;
          bp        <= bp + BAW'(1);
          rem       <= rem - CNT_W'(1);
          if (rem == CNT_W'(1)) begin
            if (c_ls && (flen_nx < FLW'(MIN_LEN))) state <= S_PAD;
            else begin
              out_last <= c_ls;
              state    <= S_WB;
            end
          end else if (bp[1:0] == 2'd3) begin
            state <= S_SRD;
          end
        end
        S_PAD: begin
          out_valid <= 1'b1;
          out_data  <= 8'h00;
          flen      <= flen_nx;
          if (flen_nx >= FLW'(MIN_LEN)) begin
            out_last <= 1'b1;
            state    <= S_WB;
          end
        end
        S_WB: begin
          if (!host_busy) begin
            irq   <= c_irq;
            cur   <= nxt;
            state <= S_D0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine #(
  parameter int AW      = 8,
  parameter int MIN_LEN = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic          host_reg,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [31:0]   host_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_irq
);
  localparam int NRD = 2;

  logic          mem_host_we;
  logic          reg_wr;
  logic [AW-1:0] base_word;
  logic          base_load;
  logic          poll;
  logic [AW-1:0] eng_addr;
  logic          eng_we;
  logic [31:0]   eng_wdata;
  logic          busy;
  logic          m_we;
  logic [AW-1:0] m_waddr;
  logic [31:0]   m_wdata;
  logic [NRD-1:0][AW-1:0] m_raddr;
  logic [NRD-1:0][31:0]   m_rdata;

  assign mem_host_we = host_we && !host_reg;
  assign reg_wr      = host_we && host_reg;
  assign m_we        = mem_host_we || eng_we;
  assign m_waddr     = mem_host_we ? host_addr  : eng_addr;
  assign m_wdata     = mem_host_we ? host_wdata : eng_wdata;
  assign m_raddr[0]  = eng_addr;
  assign m_raddr[1]  = host_raddr;
  assign host_rdata  = m_rdata[1];

  tx_ring_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (reg_wr),
    .sel_poll (host_addr[0]),
    .wval     (host_wdata[AW+1:2]),
    .base_word(base_word),
    .base_load(base_load),
    .poll     (poll)
  );

  tx_ring_mem #(.AW(AW), .NRD(NRD)) u_mem (
    .clk  (clk),
    .we   (m_we),
    .waddr(m_waddr),
    .wdata(m_wdata),
    .raddr(m_raddr),
    .rdata(m_rdata)
  );

  tx_ring_seq #(.AW(AW), .MIN_LEN(MIN_LEN)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .poll     (poll),
    .base_load(base_load),
    .base_word(base_word),
    .host_busy(mem_host_we),
    .rd_data  (m_rdata[0]),
    .eng_addr (eng_addr),
    .eng_we   (eng_we),
    .eng_wdata(eng_wdata),
    .busy     (busy),
    .out_valid(tx_valid),
    .out_data (tx_data),
    .out_last (tx_last),
    .irq      (tx_irq)
  );
endmodule

// File: rtl/tx_ring_engine_chk.sv
module tx_ring_engine_chk #(
  parameter int MIN_LEN = 60
) (
  input logic        clk,
  input logic        rst,
  input logic        tx_valid,
  input logic        tx_last,
  input logic        tx_irq,
  input logic        busy,
  input logic        eng_we,
  input logic [31:0] eng_wdata,
  input logic        mem_host_we
);
  logic [15:0] nbytes;

  always_ff @(posedge clk) begin
    if (rst) nbytes <= '0;
    else if (tx_valid) nbytes <= tx_last ? '0 : nbytes + 16'd1;
  end

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);

  p_out_active_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  p_wb_release_r6: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> !eng_wdata[31]);

  p_wb_yield_r6: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> !mem_host_we);

  p_min_len_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_last) |-> ((nbytes + 16'd1) >= 16'(MIN_LEN)));
endmodule

bind tx_ring_engine tx_ring_engine_chk #(.MIN_LEN(MIN_LEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_valid   (tx_valid),
  .tx_last    (tx_last),
  .tx_irq     (tx_irq),
  .busy       (busy),
  .eng_we     (eng_we),
  .eng_wdata  (eng_wdata),
  .mem_host_we(mem_host_we)
);

// File: tb/tx_ring_engine_bench.sv
`timescale 1ns/1ps
module tx_ring_engine_bench;
  localparam int AW = 8;
  localparam int MINF = 60;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] CI  = 32'h8000_0000;
  localparam logic [31:0] CL  = 32'h4000_0000;
  localparam logic [31:0] CF  = 32'h2000_0000;
  localparam logic [31:0] CS  = 32'h0800_0000;
  localparam logic [31:0] CE  = 32'h0200_0000;
  localparam logic [31:0] CC  = 32'h0100_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0, host_reg = 1'b0;
  logic [AW-1:0] host_addr = '0, host_raddr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic tx_valid, tx_last, tx_irq;
  logic [7:0] tx_data;

  always #4 clk = ~clk;

  tx_ring_engine #(.AW(AW), .MIN_LEN(MINF)) u_tx_ring_engine (
    .clk(clk), .rst(rst), .host_we(host_we), .host_reg(host_reg),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_raddr(host_raddr),
    .host_rdata(host_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_irq(tx_irq)
  );

  int total = 0;
  int bad = 0;
  int irq_seen = 0;
  int bytes_seen = 0;
  int mflen = 0;
  string cur_req = "R3";
  logic [8:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_irq) irq_seen++;
      if (tx_valid) begin
        bytes_seen++;
        if (expq.size() == 0) begin
          chk(1'b0, cur_req, int'({tx_last, tx_data}), -1);
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          chk({tx_last, tx_data} == e, cur_req, int'({tx_last, tx_data}), int'(e));
        end
      end
    end
  end

  task automatic wr_mem(input int waddr, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_reg = 1'b0; host_addr = AW'(waddr); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wr_reg(input bit sel_poll, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_reg = 1'b1; host_addr = AW'(sel_poll); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0; host_reg = 1'b0;
  endtask

  task automatic rd_mem(input int waddr, output logic [31:0] v);
    @(negedge clk);
    host_raddr = AW'(waddr);
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic put_desc(input int d, input logic [31:0] st, input logic [31:0] ct,
                          input int b1, input int b2);
    wr_mem(d / 4,     st);
    wr_mem(d / 4 + 1, ct);
    wr_mem(d / 4 + 2, 32'(b1));
    wr_mem(d / 4 + 3, 32'(b2));
  endtask

  task automatic seg(input int b1, input int len, input bit fs, input bit ls);
    if (fs) mflen = 0;
    for (int k = 0; k < len; k++) begin
      mflen++;
      expq.push_back({ls && (k == len - 1) && (mflen >= MINF), pat(b1 + k)});
    end
    if (ls) while (mflen < MINF) begin
      mflen++;
      expq.push_back({mflen == MINF, 8'h00});
    end
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (expq.size() != 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (30) @(negedge clk);
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic check_status(input int d, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd_mem(d / 4, v);
    chk(v == exp, req, int'(v), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int w = 128; w < 256; w++)
      wr_mem(w, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
    // R1: quiet after reset, no poll written yet
    chk(tx_valid == 1'b0, "R1", int'(tx_valid), 0);
    chk(tx_irq == 1'b0, "R1", int'(tx_irq), 0);
    chk(bytes_seen == 0 && irq_seen == 0, "R1", bytes_seen + irq_seen, 0);

    // R3: 70 bytes from an unaligned buffer, with interrupt (R7)
    cur_req = "R3"; irq_seen = 0;
    put_desc(0, OWN, CI | CL | CF | 32'd70, 513, 0);
    put_desc(16, 32'h0, 32'h0, 0, 0);
    seg(513, 70, 1, 1);
    wr_reg(0, 32'd0);
    wr_reg(1, 32'd1);
    drain("R3");
    chk(irq_seen == 1, "R7", irq_seen, 1);
    check_status(0, 32'h0, "R6");

    // R2: halted on host-owned descriptor until poll
    cur_req = "R2"; irq_seen = 0;
    put_desc(32, 32'h0, 32'h0, 0, 0);
    put_desc(16, OWN, CL | CF | 32'd10, 600, 0);
    b0 = bytes_seen;
    repeat (40) @(negedge clk);
    chk(bytes_seen == b0, "R2", bytes_seen - b0, 0);
    cur_req = "R4";
    seg(600, 10, 1, 1);
    wr_reg(1, 32'd1);
    drain("R4");
    chk(irq_seen == 0, "R7", irq_seen, 0);
    check_status(16, 32'h0, "R6");

    // R4 and R9: two segments, base reloaded
    cur_req = "R9"; irq_seen = 0;
    put_desc(64, OWN, CF | 32'd20, 700, 0);
    put_desc(80, OWN, CI | CL | 32'd15, 800, 0);
    put_desc(96, 32'h0, 32'h0, 0, 0);
    seg(700, 20, 1, 0);
    seg(800, 15, 0, 1);
    wr_reg(0, 32'd64);
    wr_reg(1, 32'd1);
    drain("R9");
    chk(irq_seen == 1, "R7", irq_seen, 1);
    check_status(80, 32'h0, "R6");

    // R5: setup descriptor consumed silently, then a 64-byte frame
    cur_req = "R5"; irq_seen = 0;
    put_desc(112, OWN, CS | 32'd192, 512, 0);
    put_desc(128, OWN, CL | CF | 32'd64, 520, 0);
    put_desc(144, 32'h0, 32'h0, 0, 0);
    seg(520, 64, 1, 1);
    wr_reg(0, 32'd112);
    wr_reg(1, 32'd1);
    drain("R5");
    check_status(112, 32'h0, "R5");
    chk(irq_seen == 0, "R7", irq_seen, 0);

    // R8: chained jump skips a trap descriptor
    cur_req = "R8"; irq_seen = 0;
    put_desc(160, OWN, CC | CL | CF | 32'd61, 900, 320);
    put_desc(176, OWN, CL | CF | 32'd3, 700, 0);
    put_desc(320, OWN, CI | CL | CF | 32'd5, 530, 0);
    put_desc(336, 32'h0, 32'h0, 0, 0);
    seg(900, 61, 1, 1);
    seg(530, 5, 1, 1);
    wr_reg(0, 32'd160);
    wr_reg(1, 32'd1);
    drain("R8");
    chk(irq_seen == 1, "R7", irq_seen, 1);
    check_status(176, OWN, "R8");

    // R8: end of ring wraps to base; exactly 60 bytes needs no pad (R4)
    cur_req = "R8"; irq_seen = 0;
    put_desc(400, OWN, CL | CF | 32'd8, 560, 0);
    put_desc(416, OWN, CE | CL | CF | 32'd60, 570, 0);
    put_desc(432, OWN, CL | CF | 32'd3, 700, 0);
    seg(560, 8, 1, 1);
    seg(570, 60, 1, 1);
    wr_reg(0, 32'd400);
    wr_reg(1, 32'd1);
    drain("R8");
    check_status(432, OWN, "R8");
    check_status(416, 32'h0, "R6");
    check_status(400, 32'h0, "R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule